// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sorts the interrupt requests of a single processor among 256 vectors. Every vector has a bit in three 256-bit banks: pending requests, vectors in service, and the trigger kind of the most recent request. Software sets a task-priority class and a spurious-vector word. The block combines these with the highest in-service vector to form the processor priority. It raises a registered interrupt line whenever the top pending request outranks that priority.

The core answers the interrupt line with an acknowledge strobe. One cycle later the block returns the vector it granted, the spurious vector when priority holds the request back, or a "none" response. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level triggered, the block also pulses a one-cycle broadcast carrying the retired vector, so that upstream level sources can re-arm.

Top module: `irqc_ctrl`

## Requirements
- R1: Synchronous reset clears the request, in-service and trigger banks, the task-priority and spurious-vector registers, `irq_out`, `ack_valid` and `eoi_bcast_valid`. After reset, `ppr_out` reads 0 and an acknowledge returns "none".
- R2: `ppr_out` equals the task-priority register when its class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that vector with bits 3:0 cleared. An empty in-service bank counts as vector 0.
- R3: A request is deliverable when the enable bit is set, the request bank is not empty, and either `ppr_out` is 0 or the class of the highest-numbered pending vector is strictly above the class of `ppr_out`. `irq_out` is a register that goes high one cycle after a nonzero top vector becomes deliverable. It goes low one cycle after that condition ends.
- R4: An acknowledge with a deliverable nonzero top vector moves that vector, the highest-numbered pending one, from the request bank to the in-service bank. In the next cycle the block gives `ack_valid`=1, `ack_none`=0 and `ack_vec`=vector.
- R5: An acknowledge while enabled, with a request pending but held back by priority, changes no bank. It returns `ack_none`=0 and `ack_vec` equal to spurious-vector bits 7:0.
- R6: An acknowledge returns `ack_valid`=1, `ack_none`=1 and `ack_vec`=0 in three cases: the block is disabled, no request is pending, or the top request is vector 0 while `ppr_out` is 0.
- R7: A request pulse sets the vector's request bit. It sets the vector's trigger bit when `req_level`=1 and clears it when `req_level`=0.
- R8: End-of-interrupt clears the highest in-service bit. If that vector's trigger bit is set and the directed bit is clear, the next cycle carries `eoi_bcast_valid`=1 and `eoi_bcast_vec`=vector. Otherwise `eoi_bcast_valid` stays 0.
- R9: End-of-interrupt with an empty in-service bank changes nothing and gives no broadcast.
- R10: A task-priority write stores `tpr_class` shifted left by four bits. The result can be seen through `ppr_out`.
- R11: A spurious-vector write keeps `svr_data` bits 8:0 (7:0 spurious vector, 8 enable) and bit 12 (directed end-of-interrupt). It drops every other bit.
- R12: A request for the same vector in the cycle that vector is acknowledged leaves the request bit set. A setting bit in a bank takes precedence over a clearing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request pulse for `req_vec` |
| req_vec | input | 8 | Vector being requested |
| req_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| ack_strobe | input | 1 | Processor acknowledge |
| eoi_strobe | input | 1 | End-of-interrupt |
| tpr_wr | input | 1 | Task-priority write |
| tpr_class | input | 4 | Task-priority class |
| svr_wr | input | 1 | Spurious-vector write |
| svr_data | input | 16 | Spurious-vector write data |
| irq_out | output | 1 | Registered interrupt request to the core |
| ack_valid | output | 1 | Acknowledge response strobe, one cycle after `ack_strobe` |
| ack_none | output | 1 | Response carries no interrupt |
| ack_vec | output | 8 | Granted or spurious vector |
| ppr_out | output | 8 | Current processor priority |
| eoi_bcast_valid | output | 1 | End-of-interrupt broadcast strobe |
| eoi_bcast_vec | output | 8 | Vector of the broadcast |

## Verification
The hardest state to reach from the ports is a request held back behind a nested in-service vector whose class exceeds the task priority. It takes a lower-class request raised first, a higher-class one raised and acknowledged above it, and the spurious response read while the first still waits. The stimulus builds that nest, then retires the in-service levels one at a time so that the processor priority steps down and the held request appears on `irq_out`. A second hard case raises a request for a vector in the very cycle that vector is acknowledged, and shows the request survives through a later spurious response.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int VW = 8;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_GRANT = 2'd1,
    RESP_SPUR  = 2'd2
  } ack_resp_e;

  // Processor priority from task priority and highest in-service vector.
  function automatic logic [VW-1:0] ppr_calc(input logic [VW-1:0] tpr,
                                             input logic isr_any,
                                             input logic [VW-1:0] isr_top);
    logic [3:0] icls;
    icls = isr_any ? isr_top[7:4] : 4'h0;
    return (tpr[7:4] >= icls) ? tpr : {icls, 4'h0};
  endfunction

  // Top request outranks current priority.
  function automatic logic can_deliver(input logic en, input logic irr_any,
                                       input logic [VW-1:0] irr_top,
                                       input logic [VW-1:0] ppr);
    return en && irr_any && ((ppr == '0) || (irr_top[7:4] > ppr[7:4]));
  endfunction

endpackage

// File: rtl/irqc_top_find.sv
module irqc_top_find #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_vecbank.sv
module irqc_vecbank #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  q
);
  logic [N-1:0] set_mask, clr_mask;

  always_comb begin
    set_mask = set_en ? (N'(1) << set_idx) : '0;
    clr_mask = clr_en ? (N'(1) << clr_idx) : '0;
  end

  // setting wins over clearing in the same cycle
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic          en,
  input  logic [VW-1:0] tpr,
  input  logic          irr_any,
  input  logic [VW-1:0] irr_top,
  input  logic          isr_any,
  input  logic [VW-1:0] isr_top,
  input  logic          ack,
  output logic [VW-1:0] ppr,
  output logic          deliver_nz,
  output logic          blocked,
  output ack_resp_e     resp
);
  logic deliver;

  always_comb begin
    ppr        = ppr_calc(tpr, isr_any, isr_top);
    deliver    = can_deliver(en, irr_any, irr_top, ppr);
    deliver_nz = deliver && (irr_top != '0);
    blocked    = en && irr_any && !deliver;
    if (!ack)            resp = RESP_NONE;
    else if (deliver_nz) resp = RESP_GRANT;
    else if (blocked)    resp = RESP_SPUR;
    else                 resp = RESP_NONE;
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NVEC = 256,
  parameter int DIR_BIT = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [7:0]    req_vec,
  input  logic          req_level,
  input  logic          ack_strobe,
  input  logic          eoi_strobe,
  input  logic          tpr_wr,
  input  logic [3:0]    tpr_class,
  input  logic          svr_wr,
  input  logic [15:0]   svr_data,
  output logic          irq_out,
  output logic          ack_valid,
  output logic          ack_none,
  output logic [7:0]    ack_vec,
  output logic [7:0]    ppr_out,
  output logic          eoi_bcast_valid,
  output logic [7:0]    eoi_bcast_vec
);
  localparam int IW = $clog2(NVEC);

  logic [NVEC-1:0] irr_bits, isr_bits, tmr_bits;
  logic            irr_any, isr_any;
  logic [IW-1:0]   irr_top, isr_top;
  logic [7:0]      tpr_q;
  logic [7:0]      spur_vec_q;
  logic            en_q, dir_q;
  logic            deliver_nz, blocked;
  ack_resp_e       resp;

  // named internal events
  logic ack_take, eoi_take, eoi_bcast_now, tmr_set, tmr_clr;

  irqc_top_find #(.N(NVEC), .IW(IW)) u_irr_find (
    .bits(irr_bits), .any(irr_any), .idx(irr_top));
  irqc_top_find #(.N(NVEC), .IW(IW)) u_isr_find (
    .bits(isr_bits), .any(isr_any), .idx(isr_top));

  irqc_arb u_arb (
    .en(en_q), .tpr(tpr_q),
    .irr_any(irr_any), .irr_top(8'(irr_top)),
    .isr_any(isr_any), .isr_top(8'(isr_top)),
    .ack(ack_strobe),
    .ppr(ppr_out), .deliver_nz(deliver_nz), .blocked(blocked), .resp(resp));

  always_comb begin
    ack_take      = (resp == RESP_GRANT);
    eoi_take      = eoi_strobe && isr_any;
    eoi_bcast_now = eoi_take && tmr_bits[isr_top] && !dir_q;
    tmr_set       = req_valid && req_level;
    tmr_clr       = req_valid && !req_level;
  end

  irqc_vecbank #(.N(NVEC), .IW(IW)) u_irr (
    .clk(clk), .rst(rst),
    .set_en(req_valid), .set_idx(IW'(req_vec)),
    .clr_en(ack_take),  .clr_idx(irr_top),
    .q(irr_bits));

  irqc_vecbank #(.N(NVEC), .IW(IW)) u_isr (
    .clk(clk), .rst(rst),
    .set_en(ack_take), .set_idx(irr_top),
    .clr_en(eoi_take), .clr_idx(isr_top),
    .q(isr_bits));

  irqc_vecbank #(.N(NVEC), .IW(IW)) u_tmr (
    .clk(clk), .rst(rst),
    .set_en(tmr_set), .set_idx(IW'(req_vec)),
    .clr_en(tmr_clr), .clr_idx(IW'(req_vec)),
    .q(tmr_bits));

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q           <= '0;
      spur_vec_q      <= '0;
      en_q            <= 1'b0;
      dir_q           <= 1'b0;
      irq_out         <= 1'b0;
      ack_valid       <= 1'b0;
      ack_none        <= 1'b0;
      ack_vec         <= '0;
      eoi_bcast_valid <= 1'b0;
      eoi_bcast_vec   <= '0;
    end else begin
      if (tpr_wr) tpr_q <= {tpr_class, 4'h0};
      if (svr_wr) begin
        spur_vec_q <= svr_data[7:0];
        en_q       <= svr_data[8];
        dir_q      <= svr_data[DIR_BIT];
      end
      irq_out   <= deliver_nz;
      ack_valid <= ack_strobe;
      ack_none  <= ack_strobe && (resp == RESP_NONE);
      case (resp)
        RESP_GRANT: ack_vec <= 8'(irr_top);
        RESP_SPUR:  ack_vec <= spur_vec_q;
        default:    ack_vec <= '0;
      endcase
      eoi_bcast_valid <= eoi_bcast_now;
      eoi_bcast_vec   <= eoi_bcast_now ? 8'(isr_top) : '0;
    end
  end

  // ---------------- assertions ----------------
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_out && !ack_valid && !eoi_bcast_valid));

  p_ppr_floor_r2: assert property (@(posedge clk) disable iff (rst)
    (ppr_out[7:4] >= tpr_q[7:4]) && (!isr_any || ppr_out[7:4] >= isr_top[7:4]));

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_out);

  p_ack_take_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !(req_valid && req_vec == 8'(irr_top)))
      |=> (isr_bits[$past(irr_top)] && !irr_bits[$past(irr_top)]));

  p_block_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_strobe && blocked && !req_valid && !eoi_strobe)
      |=> ($stable(irr_bits) && $stable(isr_bits)));

  p_edge_clear_r7: assert property (@(posedge clk) disable iff (rst)
    tmr_clr |=> !tmr_bits[$past(IW'(req_vec))]);

  p_bcast_source_r8: assert property (@(posedge clk) disable iff (rst)
    eoi_bcast_valid |-> $past(eoi_strobe));

endmodule

// File: tb/irqc_ctrl_tb.sv
module irqc_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_level, ack_strobe, eoi_strobe, tpr_wr, svr_wr;
  logic [7:0] req_vec;
  logic [3:0] tpr_class;
  logic [15:0] svr_data;
  logic irq_out, ack_valid, ack_none, eoi_bcast_valid;
  logic [7:0] ack_vec, ppr_out, eoi_bcast_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_ctrl u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
    .ack_strobe(ack_strobe), .eoi_strobe(eoi_strobe),
    .tpr_wr(tpr_wr), .tpr_class(tpr_class),
    .svr_wr(svr_wr), .svr_data(svr_data),
    .irq_out(irq_out), .ack_valid(ack_valid), .ack_none(ack_none),
    .ack_vec(ack_vec), .ppr_out(ppr_out),
    .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic raise(input logic [7:0] v, input logic lvl);
    req_valid = 1'b1; req_vec = v; req_level = lvl;
    tick();
    req_valid = 1'b0; req_level = 1'b0; req_vec = '0;
  endtask

  task automatic set_svr(input logic [15:0] d);
    svr_wr = 1'b1; svr_data = d;
    tick();
    svr_wr = 1'b0; svr_data = '0;
  endtask

  task automatic set_tpr(input logic [3:0] c);
    tpr_wr = 1'b1; tpr_class = c;
    tick();
    tpr_wr = 1'b0; tpr_class = '0;
  endtask

  // acknowledge; response is registered and seen at the following negedge
  task automatic acknowledge(input string tag, input bit exp_none, input int exp_vec);
    ack_strobe = 1'b1;
    tick();
    ack_strobe = 1'b0;
    check({tag, " ack_valid"}, ack_valid, 1);
    check({tag, " ack_none"}, ack_none, exp_none);
    check({tag, " ack_vec"}, ack_vec, exp_vec);
  endtask

  task automatic end_irq(input string tag, input bit exp_bc, input int exp_vec);
    eoi_strobe = 1'b1;
    tick();
    eoi_strobe = 1'b0;
    check({tag, " bcast_valid"}, eoi_bcast_valid, exp_bc);
    if (exp_bc) check({tag, " bcast_vec"}, eoi_bcast_vec, exp_vec);
  endtask

  task automatic irq_is(input string tag, input int exp);
    tick();  // irq_out lags the state by one register
    check({tag, " irq_out"}, irq_out, exp);
  endtask

  task automatic t_reset();
    check("R1 irq_out", irq_out, 0);
    check("R1 ppr_out", ppr_out, 0);
    check("R1 bcast", eoi_bcast_valid, 0);
    check("R1 ack_valid idle", ack_valid, 0);
    acknowledge("R1 reset ack", 1, 0);
  endtask

  task automatic t_disabled();
    raise(8'h40, 1'b0);
    irq_is("R3 disabled", 0);
    acknowledge("R6 disabled", 1, 0);
  endtask

  task automatic t_deliver();
    set_svr(16'h01FF);
    irq_is("R3 enabled", 1);
    acknowledge("R4 grant 0x40", 0, 8'h40);
    check("R2 ppr from isr", ppr_out, 8'h40);
    irq_is("R3 drained", 0);
    end_irq("R8 edge no bcast", 0, 0);
  endtask

  task automatic t_nesting();
    raise(8'h35, 1'b0);
    raise(8'h50, 1'b1);
    irq_is("R3 nest", 1);
    acknowledge("R4 highest first", 0, 8'h50);
    check("R2 ppr 0x50", ppr_out, 8'h50);
    irq_is("R3 held back", 0);
    acknowledge("R5 spurious", 0, 8'hFF);
    check("R5 ppr unchanged", ppr_out, 8'h50);
    end_irq("R8 level bcast", 1, 8'h50);
    check("R8 ppr after eoi", ppr_out, 8'h00);
    irq_is("R3 released", 1);
    acknowledge("R5 request kept", 0, 8'h35);
    end_irq("R7 edge no bcast", 0, 0);
    end_irq("R9 empty eoi", 0, 0);
    check("R9 ppr", ppr_out, 0);
  endtask

  task automatic t_tpr();
    set_tpr(4'h6);
    check("R10 tpr 6", ppr_out, 8'h60);
    raise(8'h65, 1'b0);
    irq_is("R3 equal class", 0);
    acknowledge("R5 equal class spurious", 0, 8'hFF);
    raise(8'h70, 1'b0);
    acknowledge("R4 above tpr", 0, 8'h70);
    check("R2 ppr 0x70", ppr_out, 8'h70);
    set_tpr(4'h8);
    check("R2 tpr above isr", ppr_out, 8'h80);
    end_irq("R7 edge 0x70", 0, 0);
    set_tpr(4'h0);
    check("R10 tpr 0", ppr_out, 8'h00);
    acknowledge("R4 grant 0x65", 0, 8'h65);
    end_irq("R8 edge 0x65", 0, 0);
  endtask

  task automatic t_directed();
    set_svr(16'h11AB);
    raise(8'h90, 1'b1);
    acknowledge("R4 grant 0x90", 0, 8'h90);
    raise(8'h20, 1'b0);
    acknowledge("R11 spurious 0xAB", 0, 8'hAB);
    end_irq("R8 directed suppresses", 0, 0);
    acknowledge("R4 grant 0x20", 0, 8'h20);
    end_irq("R8 edge 0x20", 0, 0);
    set_svr(16'hE1C3);  // bit12=0, bit8=1, vector 0xC3
    raise(8'hB0, 1'b1);
    acknowledge("R4 grant 0xB0", 0, 8'hB0);
    raise(8'h10, 1'b0);
    acknowledge("R11 spurious 0xC3", 0, 8'hC3);
    end_irq("R11 directed dropped", 1, 8'hB0);
    acknowledge("R4 grant 0x10", 0, 8'h10);
    end_irq("R8 edge 0x10", 0, 0);
  endtask

  task automatic t_same_vec();
    raise(8'hA0, 1'b0);
    ack_strobe = 1'b1; req_valid = 1'b1; req_vec = 8'hA0; req_level = 1'b0;
    tick();
    ack_strobe = 1'b0; req_valid = 1'b0; req_vec = '0;
    check("R12 grant", ack_vec, 8'hA0);
    acknowledge("R12 request survives", 0, 8'hC3);
    end_irq("R12 eoi", 0, 0);
    acknowledge("R12 regrant", 0, 8'hA0);
    end_irq("R12 eoi2", 0, 0);
  endtask

  task automatic t_level_retrigger();
    raise(8'hC0, 1'b1);
    raise(8'hC0, 1'b0);  // edge request clears the level mark
    acknowledge("R7 grant 0xC0", 0, 8'hC0);
    end_irq("R7 trigger cleared", 0, 0);
  endtask

  task automatic t_disable_irq();
    raise(8'h80, 1'b0);
    irq_is("R3 pending", 1);
    set_svr(16'h0000);
    irq_is("R3 disable drops irq", 0);
    acknowledge("R6 disabled again", 1, 0);
    set_svr(16'h01FF);
    acknowledge("R4 grant 0x80", 0, 8'h80);
    end_irq("R8 edge 0x80", 0, 0);
  endtask

  task automatic t_vec0();
    raise(8'h00, 1'b0);
    irq_is("R3 vector 0", 0);
    acknowledge("R6 vector 0", 1, 0);
  endtask

  initial begin
    rst = 1'b1;
    req_valid = 0; req_vec = 0; req_level = 0; ack_strobe = 0; eoi_strobe = 0;
    tpr_wr = 0; tpr_class = 0; svr_wr = 0; svr_data = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_disabled();
    t_deliver();
    t_nesting();
    t_tpr();
    t_directed();
    t_same_vec();
    t_level_retrigger();
    t_disable_irq();
    t_vec0();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule